// File: doc/BRIEF.md
# Burst Column Sequencer

This block sits behind the command decoder of a synchronous graphics memory and turns one read or write command into a stream of column addresses, one per clock, inside a page of 256 columns. When a command is taken it latches the start column, the burst length code, the ordering (linear or wrapping) and the auto-precharge request. It then steps through the page until the burst ends on its own, is halted by a burst-stop or a precharge of its own bank, or is replaced by a newer command. A burst opened with auto-precharge is locked: nothing can cut it short. When it finishes, the block raises a one-cycle request to close that bank. Full-page bursts never lock and never request a precharge.

Next to the address stream, the block times the read side. A read-valid flag marks when read data is due, which is the programmed CAS latency after the command. The byte mask is delayed by two clocks for reads. For writes it is used in the same clock as the data beat.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `col_valid`, `burst_done`, `ap_req`, `rd_valid`, `rd_mask`, `wr_mask` and `col_addr` are all zero. Raising `rst` during a burst ends it.
- R2: A command sampled at clock edge N makes beat i of the burst appear on `col_addr` after edge N+i, with `col_valid` high. In linear order (`wrap_en`=0) beat i is (start + i) mod 256.
- R3: In wrap order (`wrap_en`=1) with a fixed length L, beat i keeps the start column's bits above log2(L) and takes its low log2(L) bits from (start + i) mod L.
- R4: `bl_code` 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Codes 4 to 6 give one beat. `burst_done` is high together with the final beat of a fixed-length burst, and `col_valid` falls on the next cycle unless a new command was taken.
- R5: `bl_code`=7 selects a full-page burst. It ignores `wrap_en` and `ap_flag`, steps linearly from 255 to 0 and keeps going, and never raises `burst_done` or `ap_req`.
- R6: A `cmd_bst` sampled during an unlocked burst makes `col_valid` zero after that same edge, with no `burst_done`.
- R7: A read (`cmd_rd`) or write (`cmd_wr`) taken during an unlocked burst replaces it. The next beat is the new start column.
- R8: A `cmd_pre` whose `pre_bank` equals the bank of the running unlocked burst stops it like R6. A precharge of another bank has no effect on the burst.
- R9: A fixed-length burst with `ap_flag`=1 is locked. It ignores `cmd_bst`, `cmd_pre` and new commands until its final beat. `ap_req` is high for exactly the final-beat cycle, with `ap_bank` giving the burst's bank.
- R10: For a read sampled at edge N, `rd_valid` is high after edge N+CL for each read beat. CL is `cl_code` when `cl_code` is 2, 3 or 4, and 3 otherwise. Write beats never raise `rd_valid`.
- R11: `rd_mask` shows the `dqm` value sampled two edges earlier. `wr_mask` shows the `dqm` sampled at the same edge as the write beat now on `col_addr`, and it is zero during read beats and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_bst | input | 1 | Burst-stop strobe |
| cmd_pre | input | 1 | Precharge strobe |
| cmd_bank | input | BANK_W | Bank of the read or write command |
| pre_bank | input | BANK_W | Bank named by the precharge |
| start_col | input | COL_W | First column of the burst |
| ap_flag | input | 1 | Auto-precharge request carried by the command |
| bl_code | input | 3 | Burst length code |
| wrap_en | input | 1 | 1 selects wrap order, 0 linear |
| cl_code | input | CL_W | CAS latency setting |
| dqm | input | DQM_W | Byte mask |
| col_addr | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A beat is present |
| burst_done | output | 1 | Current beat is the last of a fixed burst |
| ap_req | output | 1 | Close the bank after this beat |
| ap_bank | output | BANK_W | Bank of the current or last burst |
| rd_valid | output | 1 | Read data due this cycle |
| rd_mask | output | DQM_W | Byte mask for read data |
| wr_mask | output | DQM_W | Byte mask for the current write beat |

## Verification
A wrong beat index or latched length shows on `col_addr` or `burst_done` on the very next beat. The bench compares every beat of every burst against a formula for linear, wrap and full-page order. A stale lock or bank latch shows as a beat that survives, or a burst that dies, one cycle after a stop, precharge or new command, and each of these is sampled in exactly that cycle. Faults in the delay lines appear as `rd_valid` or `rd_mask` a cycle early or late. The bench walks each latency setting and one isolated mask value to catch this.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int BL_W = 3;

  typedef enum logic [BL_W-1:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd7
  } bl_code_e;

  // length minus one for fixed bursts; reserved codes act as a single beat
  function automatic int unsigned beat_mask(logic [BL_W-1:0] code);
    case (code)
      BL_TWO:   return 1;
      BL_FOUR:  return 3;
      BL_EIGHT: return 7;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/bcs_col_calc.sv
module bcs_col_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             wrap,
  input  logic             full,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] lin;

  always_comb begin
    lin = base + idx;
    if (wrap && !full) col = (base & ~mask) | (lin & mask);
    else               col = lin;
  end
endmodule

// File: rtl/bcs_pipe.sv
module bcs_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     d,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[sel];
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 1,
  parameter int DQM_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_bst,
  input  logic              cmd_pre,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic [COL_W-1:0]  start_col,
  input  logic              ap_flag,
  input  logic [BL_W-1:0]   bl_code,
  input  logic              wrap_en,
  input  logic [DQM_W-1:0]  dqm,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              burst_done,
  output logic              ap_req,
  output logic [BANK_W-1:0] ap_bank,
  output logic              beat_wr,
  output logic [DQM_W-1:0]  wr_mask,
  output logic              locked
);
  logic [COL_W-1:0]  base_q, idx_q, mask_q, col_q, nxt_idx, nxt_col, new_mask;
  logic [BANK_W-1:0] bank_q;
  logic valid_q, done_q, apreq_q, ap_q, wr_q, full_q, wrap_q;
  logic [DQM_W-1:0] wrm_q;
  logic new_full, new_ap, new_done, start, halt, cont, cont_done;

  bcs_col_calc #(.COL_W(COL_W)) u_calc (
    .base(base_q), .idx(nxt_idx), .mask(mask_q),
    .wrap(wrap_q), .full(full_q), .col(nxt_col)
  );

  always_comb begin
    locked    = valid_q && ap_q && !done_q;
    start     = (cmd_rd || cmd_wr) && !locked;
    halt      = !locked && (cmd_bst || (cmd_pre && (pre_bank == bank_q)));
    cont      = valid_q && !done_q && !halt;
    nxt_idx   = idx_q + COL_W'(1);
    cont_done = !full_q && (nxt_idx == mask_q);
    new_mask  = COL_W'(beat_mask(bl_code));
    new_full  = (bl_code == BL_PAGE);
    new_ap    = ap_flag && !new_full;
    new_done  = !new_full && (new_mask == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0; done_q <= 1'b0; apreq_q <= 1'b0; ap_q <= 1'b0;
      wr_q    <= 1'b0; full_q <= 1'b0; wrap_q  <= 1'b0;
      base_q  <= '0;   idx_q  <= '0;   mask_q  <= '0;   col_q <= '0;
      bank_q  <= '0;   wrm_q  <= '0;
    end else if (start) begin
      valid_q <= 1'b1;
      idx_q   <= '0;
      base_q  <= start_col;
      col_q   <= start_col;
      mask_q  <= new_mask;
      full_q  <= new_full;
      wrap_q  <= wrap_en;
      ap_q    <= new_ap;
      wr_q    <= cmd_wr;
      bank_q  <= cmd_bank;
      done_q  <= new_done;
      apreq_q <= new_done && new_ap;
      wrm_q   <= cmd_wr ? dqm : '0;
    end else if (cont) begin
      idx_q   <= nxt_idx;
      col_q   <= nxt_col;
      done_q  <= cont_done;
      apreq_q <= cont_done && ap_q;
      wrm_q   <= wr_q ? dqm : '0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      apreq_q <= 1'b0;
      wrm_q   <= '0;
    end
  end

  assign col_addr   = col_q;
  assign col_valid  = valid_q;
  assign burst_done = done_q;
  assign ap_req     = apreq_q;
  assign ap_bank    = bank_q;
  assign beat_wr    = wr_q;
  assign wr_mask    = wrm_q;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W       = 8,
  parameter int BANK_W      = 1,
  parameter int DQM_W       = 4,
  parameter int CL_W        = 3,
  parameter int MAX_CL      = 4,
  parameter int RD_MASK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_bst,
  input  logic              cmd_pre,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic [COL_W-1:0]  start_col,
  input  logic              ap_flag,
  input  logic [BL_W-1:0]   bl_code,
  input  logic              wrap_en,
  input  logic [CL_W-1:0]   cl_code,
  input  logic [DQM_W-1:0]  dqm,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              burst_done,
  output logic              ap_req,
  output logic [BANK_W-1:0] ap_bank,
  output logic              rd_valid,
  output logic [DQM_W-1:0]  rd_mask,
  output logic [DQM_W-1:0]  wr_mask
);
  localparam int CL_SEL_W = $clog2(MAX_CL);
  localparam int MK_DEPTH = RD_MASK_LAT + 1;
  localparam int MK_SEL_W = $clog2(MK_DEPTH) < 1 ? 1 : $clog2(MK_DEPTH);

  logic                beat_wr, locked, rd_beat;
  logic [CL_W-1:0]     cl_eff;
  logic [CL_SEL_W-1:0] cl_sel;

  bcs_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W), .DQM_W(DQM_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_bst(cmd_bst), .cmd_pre(cmd_pre),
    .cmd_bank(cmd_bank), .pre_bank(pre_bank), .start_col(start_col),
    .ap_flag(ap_flag), .bl_code(bl_code), .wrap_en(wrap_en), .dqm(dqm),
    .col_addr(col_addr), .col_valid(col_valid), .burst_done(burst_done),
    .ap_req(ap_req), .ap_bank(ap_bank), .beat_wr(beat_wr),
    .wr_mask(wr_mask), .locked(locked)
  );

  always_comb begin
    if (cl_code >= CL_W'(2) && cl_code <= CL_W'(MAX_CL)) cl_eff = cl_code;
    else                                                  cl_eff = CL_W'(3);
    cl_sel  = CL_SEL_W'(cl_eff - CL_W'(1));
    rd_beat = col_valid && !beat_wr;
  end

  bcs_pipe #(.W(1), .DEPTH(MAX_CL), .SEL_W(CL_SEL_W)) u_rdv (
    .clk(clk), .rst(rst), .d(rd_beat), .sel(cl_sel), .q(rd_valid)
  );

  bcs_pipe #(.W(DQM_W), .DEPTH(MK_DEPTH), .SEL_W(MK_SEL_W)) u_rdm (
    .clk(clk), .rst(rst), .d(dqm), .sel(MK_SEL_W'(RD_MASK_LAT)), .q(rd_mask)
  );
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int DQM_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_bst,
  input logic             locked,
  input logic [DQM_W-1:0] dqm,
  input logic             col_valid,
  input logic             burst_done,
  input logic             ap_req,
  input logic [DQM_W-1:0] rd_mask,
  input logic [DQM_W-1:0] wr_mask
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_done_has_beat_R4: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> col_valid);

  assert_bst_halts_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_bst && !cmd_rd && !cmd_wr && !locked) |=> !col_valid);

  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (rst)
    locked |=> col_valid);

  assert_apreq_last_R9: assert property (@(posedge clk) disable iff (rst)
    ap_req |-> (burst_done && col_valid));

  assert_rdmask_delay_R11: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (rd_mask == $past(dqm, 3)));

  assert_wrmask_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !col_valid |-> (wr_mask == '0));
endmodule

bind burst_col_seq burst_col_seq_chk #(.DQM_W(DQM_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_bst(cmd_bst),
  .locked(locked), .dqm(dqm), .col_valid(col_valid), .burst_done(burst_done),
  .ap_req(ap_req), .rd_mask(rd_mask), .wr_mask(wr_mask)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_rd = 0, cmd_wr = 0, cmd_bst = 0, cmd_pre = 0;
  logic [0:0] cmd_bank = '0, pre_bank = '0;
  logic [7:0] start_col = '0;
  logic       ap_flag = 0, wrap_en = 0;
  logic [2:0] bl_code = '0, cl_code = 3'd2;
  logic [3:0] dqm = '0;
  logic [7:0] col_addr;
  logic       col_valid, burst_done, ap_req, rd_valid;
  logic [0:0] ap_bank;
  logic [3:0] rd_mask, wr_mask;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  burst_col_seq dut_i (
    .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_bst(cmd_bst),
    .cmd_pre(cmd_pre), .cmd_bank(cmd_bank), .pre_bank(pre_bank),
    .start_col(start_col), .ap_flag(ap_flag), .bl_code(bl_code),
    .wrap_en(wrap_en), .cl_code(cl_code), .dqm(dqm), .col_addr(col_addr),
    .col_valid(col_valid), .burst_done(burst_done), .ap_req(ap_req),
    .ap_bank(ap_bank), .rd_valid(rd_valid), .rd_mask(rd_mask), .wr_mask(wr_mask)
  );

  // stimulus / expected table: start, length code, wrap, beat count, last column
  localparam int V_START [8] = '{'h10, 'hFF, 'h0E, 'h0E, 'h35, 'hFC, 'h07, 'h40};
  localparam int V_BL    [8] = '{0, 1, 2, 2, 3, 3, 1, 5};
  localparam int V_WRAP  [8] = '{0, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_CNT   [8] = '{1, 2, 4, 4, 8, 8, 2, 1};
  localparam int V_LAST  [8] = '{'h10, 'h00, 'h0D, 'h11, 'h34, 'h03, 'h06, 'h40};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lmask(int bl);
    case (bl)
      1: return 1;
      2: return 3;
      3: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int expcol(int s, int i, int bl, int w);
    int m, lin;
    m   = lmask(bl);
    lin = (s + i) & 255;
    if (w != 0 && bl != 7) return (s & ~m & 255) | (lin & m);
    return lin;
  endfunction

  task automatic issue(bit wr, int s, int bl, bit w, bit ap, bit bank);
    cmd_rd = !wr; cmd_wr = wr;
    start_col = 8'(s); bl_code = 3'(bl); wrap_en = w; ap_flag = ap; cmd_bank = bank;
    @(negedge clk);
    cmd_rd = 0; cmd_wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, last;
    dqm = 4'hF;
    idle(3);
    // R1: outputs cleared while reset is held
    chk("R1 col_valid in reset", col_valid, 0);
    chk("R1 rd_mask in reset", rd_mask, 0);
    dqm = '0;
    rst = 0;
    @(negedge clk);
    chk("R1 col_valid", col_valid, 0);
    chk("R1 burst_done", burst_done, 0);
    chk("R1 ap_req", ap_req, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_mask", wr_mask, 0);
    chk("R1 col_addr", col_addr, 0);

    // table walk: R2 linear, R3 wrap, R4 lengths
    for (int v = 0; v < 8; v++) begin
      issue(0, V_START[v], V_BL[v], V_WRAP[v][0], 0, 0);
      n = 0; last = -1;
      while (col_valid && n < 16) begin
        if (V_WRAP[v] != 0) chk("R3 wrap column", col_addr, expcol(V_START[v], n, V_BL[v], 1));
        else                chk("R2 linear column", col_addr, expcol(V_START[v], n, V_BL[v], 0));
        chk("R4 done flag", burst_done, (n == V_CNT[v] - 1) ? 1 : 0);
        last = col_addr; n++;
        @(negedge clk);
      end
      chk("R4 beat count", n, V_CNT[v]);
      chk("R4 last column", last, V_LAST[v]);
    end

    // R5 full page with wrap and auto-precharge requested, then R6 burst-stop
    issue(0, 'hFD, 7, 1, 1, 0);
    for (int i = 0; i < 260; i++) begin
      chk("R5 page column", col_addr, (('hFD + i) & 255));
      chk("R5 page no done", burst_done, 0);
      chk("R5 page no ap_req", ap_req, 0);
      if (i == 259) cmd_bst = 1;
      @(negedge clk);
    end
    cmd_bst = 0;
    chk("R6 stop full page", col_valid, 0);

    // R6 burst-stop on fixed length
    issue(0, 'h20, 3, 0, 0, 0);
    chk("R6 beat0", col_addr, 'h20);
    @(negedge clk);
    chk("R6 beat1", col_addr, 'h21);
    cmd_bst = 1;
    @(negedge clk);
    cmd_bst = 0;
    chk("R6 halted", col_valid, 0);
    chk("R6 no done", burst_done, 0);

    // R8 precharge: other bank ignored, own bank stops
    issue(0, 'h30, 3, 0, 0, 1);
    chk("R8 beat0", col_addr, 'h30);
    cmd_pre = 1; pre_bank = 0;
    @(negedge clk);
    cmd_pre = 0;
    chk("R8 other bank keeps valid", col_valid, 1);
    chk("R8 other bank keeps column", col_addr, 'h31);
    cmd_pre = 1; pre_bank = 1;
    @(negedge clk);
    cmd_pre = 0;
    chk("R8 own bank halts", col_valid, 0);

    // R7 interrupt by a write, R11 write mask alignment
    dqm = 4'hF;
    issue(0, 'h50, 3, 0, 0, 0);
    chk("R7 beat0", col_addr, 'h50);
    chk("R11 wr_mask zero on read", wr_mask, 0);
    @(negedge clk);
    chk("R7 beat1", col_addr, 'h51);
    dqm = 4'h5;
    issue(1, 'h90, 1, 0, 0, 0);
    chk("R7 new start column", col_addr, 'h90);
    chk("R7 valid", col_valid, 1);
    chk("R11 wr_mask beat0", wr_mask, 5);
    dqm = 4'h3;
    @(negedge clk);
    chk("R7 second write beat", col_addr, 'h91);
    chk("R7 done", burst_done, 1);
    chk("R11 wr_mask beat1", wr_mask, 3);
    dqm = 4'h0;
    @(negedge clk);
    chk("R7 ended", col_valid, 0);
    chk("R11 wr_mask idle", wr_mask, 0);

    // R9 locked auto-precharge burst
    issue(0, 'h62, 2, 1, 1, 1);
    chk("R9 beat0", col_addr, 'h62);
    chk("R9 no early ap_req", ap_req, 0);
    cmd_bst = 1;
    @(negedge clk);
    cmd_bst = 0;
    chk("R9 bst ignored", col_addr, 'h63);
    cmd_wr = 1; start_col = 'h99;
    @(negedge clk);
    cmd_wr = 0;
    chk("R9 write ignored", col_addr, 'h60);
    chk("R9 no early ap_req 2", ap_req, 0);
    cmd_pre = 1; pre_bank = 1;
    @(negedge clk);
    cmd_pre = 0;
    chk("R9 precharge ignored", col_addr, 'h61);
    chk("R9 done", burst_done, 1);
    chk("R9 ap_req", ap_req, 1);
    chk("R9 ap_bank", ap_bank, 1);
    @(negedge clk);
    chk("R9 ended", col_valid, 0);
    chk("R9 ap_req one cycle", ap_req, 0);

    // R10 read latency for several settings
    for (int c = 0; c < 4; c++) begin
      int clv, expl;
      clv  = (c == 3) ? 0 : c + 2;
      expl = (c == 3) ? 3 : clv;
      cl_code = 3'(clv);
      idle(6);
      issue(0, 'h10, 0, 0, 0, 0);
      for (int k = 0; k < 7; k++) begin
        chk("R10 rd_valid timing", rd_valid, (k == expl) ? 1 : 0);
        @(negedge clk);
      end
    end
    cl_code = 3'd2;
    idle(6);
    issue(1, 'h10, 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) begin
      chk("R10 no rd_valid on write", rd_valid, 0);
      @(negedge clk);
    end

    // R11 read mask delay
    idle(4);
    dqm = 4'hA;
    @(negedge clk);
    dqm = 4'h0;
    chk("R11 rd_mask +0", rd_mask, 0);
    @(negedge clk);
    chk("R11 rd_mask +1", rd_mask, 0);
    @(negedge clk);
    chk("R11 rd_mask +2", rd_mask, 'hA);
    @(negedge clk);
    chk("R11 rd_mask +3", rd_mask, 0);

    // R1 reset during a burst
    issue(0, 'h70, 3, 0, 0, 0);
    rst = 1;
    @(negedge clk);
    chk("R1 reset ends burst", col_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 stays idle", col_valid, 0);

    finish_run();
  end
endmodule